// File: doc/BRIEF.md
# Serializing-Instruction Barrier Controller

This block sits between instruction fetch and dispatch and keeps serializing instructions in order. Each instruction arrives on a valid/ready stream with a sequence tag, a payload and a small set of one-hot attribute bits. Ordinary instructions pass straight through. An instruction that must wait for all older work to finish is taken out of the stream and parked in a single holding register. Dispatch is then blocked until the back end reports an empty reorder buffer and the downstream instruction queue reports that it is empty. The parked instruction is then sent on with its wait-before attribute cleared, and the stream resumes.

An instruction that must finish before anything younger may start is not held itself. It is forwarded and marked as handled, and the instruction after it is tagged wait-before, so the delay lands on its successor. A handled bit keeps an instruction from blocking twice. A pipeline flush that reaches the parked instruction discards it. Three counters track barriers entered, temporary barriers entered and cycles spent blocked.

Top module: `ser_barrier_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0, all three counters read 0, no barrier is held and `in_ready` equals `out_ready`.
- R2: With no barrier held, an instruction whose attribute bits `in_kind` (bit 0 wait-before, bit 1 register-access, bit 2 wait-after, bit 3 store-conditional; all zero for an ordinary instruction) call for no barrier appears on the output in the same cycle with its tag and payload unchanged, and `in_ready` equals `out_ready`.
- R3: Once an unhandled wait-after or store-conditional instruction is accepted, the next accepted instruction is treated as wait-before. It shows `out_ser_before`=1 and, if unhandled, becomes a barrier. The pending mark is cleared by that acceptance.
- R4: An unhandled wait-after or store-conditional instruction is forwarded with `out_handled`=1 and adds 1 to `ser_count`.
- R5: An accepted unhandled instruction that is wait-before (including one made so under R3) or register-access is not forwarded. It is held, and while it is held `in_ready` is 0 and nothing else is accepted.
- R6: A held barrier with `in_temp`=0 adds 1 to `ser_count` and is released with `out_handled`=1. A held barrier with `in_temp`=1 adds 1 to `tmp_count` instead and is released with `out_handled`=0.
- R7: The controller leaves the blocked phase only at a clock edge where `rob_empty` and `iq_empty` are both 1. It starts presenting the barrier in the following cycle.
- R8: While the barrier is presented, `out_valid`=1 with the held tag and payload and `out_ser_before`=0. This holds until `out_ready` is 1, after which normal flow resumes.
- R9: `stall_count` rises by 1 for every clock edge at which the controller is in the blocked phase.
- R10: A `squash_valid` pulse with `squash_seq` less than the held tag, during the blocked or presenting phase, discards the barrier and returns to normal flow. This takes priority over a drain in the same cycle. A squash whose `squash_seq` is not below the held tag is ignored.
- R11: An instruction that is wait-before but already handled passes through with `out_ser_before`=1 and does not block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Incoming instruction accepted |
| in_seq | input | SEQ_W | Sequence tag, larger is younger |
| in_payload | input | PAY_W | Opaque instruction payload |
| in_kind | input | 4 | One-hot attributes: wait-before, register-access, wait-after, store-conditional |
| in_temp | input | 1 | Barrier is temporary |
| in_handled | input | 1 | Serialization already handled |
| out_valid | output | 1 | Outgoing instruction valid |
| out_ready | input | 1 | Dispatch accepts instruction |
| out_seq | output | SEQ_W | Outgoing tag |
| out_payload | output | PAY_W | Outgoing payload |
| out_ser_before | output | 1 | Outgoing wait-before attribute |
| out_handled | output | 1 | Outgoing handled attribute |
| rob_empty | input | 1 | Back-end reorder buffer empty |
| iq_empty | input | 1 | Instruction queue holds zero entries |
| squash_valid | input | 1 | Flush request |
| squash_seq | input | SEQ_W | Tag of oldest surviving instruction |
| ser_count | output | CNT_W | Barriers and wait-after events counted |
| tmp_count | output | CNT_W | Temporary barriers counted |
| stall_count | output | CNT_W | Blocked cycles counted |

## Verification
The two functions that can land in one cycle are the drain release and a flush of the held barrier. The bench raises `rob_empty`, `iq_empty` and `squash_valid` together while a barrier is blocked, with the squash tag both below and not below the held tag. A younger barrier must vanish without ever being presented. An older one must go on to be presented in the next cycle. The random phase reproduces the same collision at random points, both during blocking and during presentation, and a cycle-level model built from the requirements decides every outcome.

// File: rtl/sbc_pkg.sv
// Package: shared encodings for the serializing barrier controller.
// Assumes attribute bits arrive one-hot or all zero.
package sbc_pkg;
    localparam int KIND_W  = 4;
    localparam int K_SB    = 0;  // wait-before
    localparam int K_REGAC = 1;  // internal register access
    localparam int K_SA    = 2;  // wait-after
    localparam int K_SC    = 3;  // store-conditional
    localparam int NUM_CNT = 3;
    localparam int C_SER   = 0;
    localparam int C_TMP   = 1;
    localparam int C_STALL = 2;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RELEASE = 2'd2
    } sbc_state_e;
endpackage

// File: rtl/sbc_classify.sv
// Module: sbc_classify
// Decides, from one incoming instruction's attributes and the pending
// wait-next mark, whether it becomes a barrier, triggers a wait-after,
// and which counter it bumps. Purely combinational; the caller qualifies
// every output with acceptance.
module sbc_classify
    import sbc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              temp,
    input  logic              handled,
    input  logic              pend_next,
    output logic              eff_sb,
    output logic              make_barrier,
    output logic              make_after,
    output logic              fwd_handled,
    output logic              ser_inc,
    output logic              tmp_inc
);
    // Attribute decode for one instruction.
    always_comb begin
        eff_sb       = kind[K_SB] | pend_next;
        make_barrier = (eff_sb | kind[K_REGAC]) & ~handled;
        make_after   = (kind[K_SA] | kind[K_SC]) & ~handled & ~make_barrier;
        fwd_handled  = handled | make_after;
        ser_inc      = (make_barrier & ~temp) | make_after;
        tmp_inc      = make_barrier & temp;
    end
endmodule

// File: rtl/sbc_hold.sv
// Module: sbc_hold
// Single-entry barrier register and the run / hold / release sequencer.
// Assumes the caller raises capture only in the run phase. A squash
// cancels the entry when the held tag is younger than the squash tag,
// with priority over drain and over release.
module sbc_hold
    import sbc_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEQ_W-1:0] cap_seq,
    input  logic [PAY_W-1:0] cap_pay,
    input  logic             cap_temp,
    input  logic             rob_empty,
    input  logic             iq_empty,
    input  logic             out_ready,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output sbc_state_e       state,
    output logic [SEQ_W-1:0] hold_seq,
    output logic [PAY_W-1:0] hold_pay,
    output logic             hold_handled
);
    sbc_state_e state_n;
    logic       cancel;

    // Squash reaches the held barrier only when it is younger.
    always_comb begin
        cancel = squash_valid && (state != ST_RUN) && (hold_seq > squash_seq);
    end

    // Next-phase selection.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_RUN:     if (capture) state_n = ST_HOLD;
            ST_HOLD:    if (cancel) state_n = ST_RUN;
                        else if (rob_empty && iq_empty) state_n = ST_RELEASE;
            ST_RELEASE: if (cancel || out_ready) state_n = ST_RUN;
            default:    state_n = ST_RUN;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_n;
    end

    // Barrier contents, loaded on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_seq     <= '0;
            hold_pay     <= '0;
            hold_handled <= 1'b0;
        end else if (capture) begin
            hold_seq     <= cap_seq;
            hold_pay     <= cap_pay;
            hold_handled <= ~cap_temp;
        end
    end
endmodule

// File: rtl/sbc_counter.sv
// Module: sbc_counter
// Free-running event counter, one step per cycle with inc high; wraps.
module sbc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count one event per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/ser_barrier_ctrl.sv
// Module: ser_barrier_ctrl
// Dispatch-side serializing barrier controller. Forwards ordinary
// instructions combinationally, parks wait-before / register-access
// instructions until the back end drains, and turns wait-after into a
// wait-before on the successor. Assumes out_ready does not depend on
// out_valid and that tags grow with age without wrapping inside a window.
module ser_barrier_ctrl
    import sbc_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int PAY_W = 16,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic [PAY_W-1:0]  in_payload,
    input  logic [KIND_W-1:0] in_kind,
    input  logic              in_temp,
    input  logic              in_handled,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_ser_before,
    output logic              out_handled,
    input  logic              rob_empty,
    input  logic              iq_empty,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic [CNT_W-1:0]  ser_count,
    output logic [CNT_W-1:0]  tmp_count,
    output logic [CNT_W-1:0]  stall_count
);
    sbc_state_e       state;
    logic [SEQ_W-1:0] hold_seq;
    logic [PAY_W-1:0] hold_pay;
    logic             hold_handled;
    logic             pend_next;
    logic             accept;
    logic             st_hold;
    logic             st_rel;
    logic             eff_sb, make_barrier, make_after, fwd_handled;
    logic             ser_inc, tmp_inc;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    sbc_classify u_cls (
        .kind        (in_kind),
        .temp        (in_temp),
        .handled     (in_handled),
        .pend_next   (pend_next),
        .eff_sb      (eff_sb),
        .make_barrier(make_barrier),
        .make_after  (make_after),
        .fwd_handled (fwd_handled),
        .ser_inc     (ser_inc),
        .tmp_inc     (tmp_inc)
    );

    sbc_hold #(.SEQ_W(SEQ_W), .PAY_W(PAY_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (accept && make_barrier),
        .cap_seq     (in_seq),
        .cap_pay     (in_payload),
        .cap_temp    (in_temp),
        .rob_empty   (rob_empty),
        .iq_empty    (iq_empty),
        .out_ready   (out_ready),
        .squash_valid(squash_valid),
        .squash_seq  (squash_seq),
        .state       (state),
        .hold_seq    (hold_seq),
        .hold_pay    (hold_pay),
        .hold_handled(hold_handled)
    );

    // Phase decode and input handshake.
    always_comb begin
        st_hold  = (state == ST_HOLD);
        st_rel   = (state == ST_RELEASE);
        in_ready = (state == ST_RUN) && out_ready;
        accept   = in_valid && in_ready;
    end

    // Output mux: held barrier when releasing, else the live input.
    always_comb begin
        if (st_rel) begin
            out_valid      = 1'b1;
            out_seq        = hold_seq;
            out_payload    = hold_pay;
            out_ser_before = 1'b0;
            out_handled    = hold_handled;
        end else begin
            out_valid      = (state == ST_RUN) && in_valid && !make_barrier;
            out_seq        = in_seq;
            out_payload    = in_payload;
            out_ser_before = eff_sb;
            out_handled    = fwd_handled;
        end
    end

    // Wait-next mark: set by a wait-after, consumed by any acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_next <= 1'b0;
        else if (accept) pend_next <= make_after;
    end

    // Counter enables.
    always_comb begin
        cnt_inc          = '0;
        cnt_inc[C_SER]   = accept && ser_inc;
        cnt_inc[C_TMP]   = accept && tmp_inc;
        cnt_inc[C_STALL] = st_hold;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        sbc_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (cnt_inc[g]),
            .q    (cnt_q[g])
        );
    end

    // Counter outputs.
    always_comb begin
        ser_count   = cnt_q[C_SER];
        tmp_count   = cnt_q[C_TMP];
        stall_count = cnt_q[C_STALL];
    end
endmodule

// File: rtl/sbc_checker.sv
// Module: sbc_checker
// Temporal properties of the barrier controller, bound to the top.
module sbc_checker #(
    parameter int SEQ_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_ser_before,
    input logic [SEQ_W-1:0] out_seq,
    input logic             squash_valid,
    input logic             st_hold,
    input logic             st_rel,
    input logic [CNT_W-1:0] ser_count,
    input logic [CNT_W-1:0] stall_count
);
    AST_HOLD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hold || st_rel) |-> !in_ready); // R5
    AST_HOLD_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        st_hold |-> !out_valid); // R5
    AST_RELEASE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        st_rel |-> (out_valid && !out_ser_before)); // R8
    AST_RELEASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rel && !out_ready && !squash_valid) |=> (st_rel && $stable(out_seq))); // R8
    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_rel) |-> $past(st_hold)); // R7
    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_hold |=> (stall_count == $past(stall_count) + CNT_W'(1))); // R9
    AST_SER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rel |=> ((ser_count == $past(ser_count)) ||
                     (ser_count == $past(ser_count) + CNT_W'(1)))); // R6
endmodule

bind ser_barrier_ctrl sbc_checker #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_ser_before(out_ser_before),
    .out_seq       (out_seq),
    .squash_valid  (squash_valid),
    .st_hold       (st_hold),
    .st_rel        (st_rel),
    .ser_count     (ser_count),
    .stall_count   (stall_count)
);

// File: tb/ser_barrier_ctrl_tb.sv
// Bench: directed corners then seeded random traffic, compared each cycle
// against a phase-level model written from the requirements.
module ser_barrier_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W = 8;
    localparam int PAY_W = 16;
    localparam int CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_temp = 0, in_handled = 0, out_ready = 0;
    logic rob_empty = 0, iq_empty = 0, squash_valid = 0;
    logic [SEQ_W-1:0] in_seq = '0, squash_seq = '0, out_seq;
    logic [PAY_W-1:0] in_payload = '0, out_payload;
    logic [3:0] in_kind = '0;
    logic in_ready, out_valid, out_ser_before, out_handled;
    logic [CNT_W-1:0] ser_count, tmp_count, stall_count;

    int checks = 0, errors = 0;
    int m_state = 0;      // 0 run, 1 hold, 2 release
    bit m_pend = 0, m_bh = 0;
    int m_bseq = 0, m_bpay = 0, m_ser = 0, m_tmp = 0, m_stall = 0;
    int nseq = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_barrier_ctrl #(.SEQ_W(SEQ_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_dut (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_bar(logic [3:0] k, bit h, bit p);
        return ((k[0] | p | k[1]) && !h);
    endfunction

    function automatic bit is_after(logic [3:0] k, bit h, bit p);
        return ((k[2] | k[3]) && !h && !is_bar(k, h, p));
    endfunction

    // One cycle: drive at negedge, compare before posedge, advance model.
    task automatic step(bit iv, logic [3:0] k, bit tmp, bit h, int pay,
                        bit ordy, bit robe, bit iqe, bit sq, int sqs);
        bit bar, aft, ev, cancel;
        int seq;
        @(negedge clk);
        seq = nseq % 256; nseq++;
        in_valid = iv; in_kind = k; in_temp = tmp; in_handled = h;
        in_seq = SEQ_W'(seq); in_payload = PAY_W'(pay); out_ready = ordy;
        rob_empty = robe; iq_empty = iqe; squash_valid = sq; squash_seq = SEQ_W'(sqs);
        #1;
        bar = is_bar(k, h, m_pend);
        aft = is_after(k, h, m_pend);
        chk(m_state == 0 ? "R2" : "R5", int'(in_ready), (m_state == 0) ? int'(ordy) : 0);
        if (m_state == 2) begin
            chk("R8", int'(out_valid), 1);
            chk("R8", int'(out_seq), m_bseq);
            chk("R8", int'(out_payload), m_bpay);
            chk("R8", int'(out_ser_before), 0);
            chk("R6", int'(out_handled), int'(m_bh));
        end else begin
            ev = (m_state == 0) && iv && !bar;
            chk(m_state == 1 ? "R7" : "R5", int'(out_valid), int'(ev));
            if (ev) begin
                chk("R2", int'(out_seq), seq);
                chk("R2", int'(out_payload), pay);
                chk(h ? "R11" : "R3", int'(out_ser_before), int'(k[0] | m_pend));
                chk("R4", int'(out_handled), int'(h | aft));
            end
        end
        chk("R6", int'(ser_count), m_ser);
        chk("R6", int'(tmp_count), m_tmp);
        chk("R9", int'(stall_count), m_stall);
        @(posedge clk);
        cancel = sq && (m_bseq > sqs);
        case (m_state)
            0: if (iv && ordy) begin
                   if (bar) begin
                       m_bseq = seq; m_bpay = pay; m_bh = !tmp; m_state = 1;
                       if (tmp) m_tmp++; else m_ser++;
                   end else if (aft) m_ser++;
                   m_pend = aft;
               end
            1: begin
                   m_stall++;
                   if (cancel) m_state = 0;
                   else if (robe && iqe) m_state = 2;
               end
            default: if (cancel || ordy) m_state = 0;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; out_ready = 1'b1;
        #1;
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(in_ready), 1);
        chk("R1", int'(ser_count), 0);
        chk("R1", int'(tmp_count), 0);
        chk("R1", int'(stall_count), 0);
        // R2: ordinary instructions, ready high and low.
        step(1, 4'b0000, 0, 0, 16'h1111, 1, 0, 0, 0, 0);
        step(1, 4'b0000, 0, 0, 16'h2222, 0, 0, 0, 0, 0);
        // R4 then R3: wait-after turns successor into barrier.
        step(1, 4'b0100, 0, 0, 16'h3333, 1, 0, 0, 0, 0);
        step(1, 4'b0000, 0, 0, 16'h4444, 1, 0, 0, 0, 0);
        // R7: partial drains do not release.
        step(1, 4'b0000, 0, 0, 16'h5555, 1, 0, 0, 0, 0);
        step(1, 4'b0000, 0, 0, 16'h5555, 1, 1, 0, 0, 0);
        step(1, 4'b0000, 0, 0, 16'h5555, 1, 0, 1, 0, 0);
        step(1, 4'b0000, 0, 0, 16'h5555, 0, 1, 1, 0, 0);
        // R8: presented while ready low, then taken.
        step(0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 0);
        // R6, R10: temporary barrier cancelled by squash on drain cycle.
        step(1, 4'b0001, 1, 0, 16'h6666, 1, 0, 0, 0, 0);
        step(0, 4'b0000, 0, 0, 0, 1, 1, 1, 1, 0);
        step(1, 4'b0000, 0, 0, 16'h7777, 1, 0, 0, 0, 0);
        // R11: handled wait-before passes.
        step(1, 4'b0001, 0, 1, 16'h8888, 1, 0, 0, 0, 0);
        // R10: squash not below held tag ignored, drain still releases.
        step(1, 4'b0010, 0, 0, 16'h9999, 1, 0, 0, 0, 0);
        step(0, 4'b0000, 0, 0, 0, 1, 1, 1, 1, 255);
        step(0, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 0);
        // Random phase.
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [3:0] k = (r < 5) ? 4'b0000 : 4'(1 << (r - 5));
            if (r == 9) k = 4'b0000;
            step(bit'($urandom_range(0, 3) != 0), k, bit'($urandom_range(0, 2) == 0),
                 bit'($urandom_range(0, 4) == 0), int'($urandom_range(0, 65535)),
                 bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 11) == 0),
                 int'($urandom_range(0, 255)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule